// File: doc/BRIEF.md
# Cartridge CPU Register Decoder and Program Banker

This block sits on the CPU side of a cartridge controller. It watches CPU write cycles and captures those aimed at a 16-byte write-only register window placed at 0x7EF0–0x7EFF. Behind that window sit six character-bank registers, a control register carrying a nametable mirroring bit and a character layout mode bit, three unlock key registers, and three program bank selectors. The character registers, the two control bits and the unlock keys are exported as flat buses so that the neighbouring character translator and save-RAM blocks can decode them.

On the read side it maps CPU program space 0x8000–0xFFFF onto program ROM in four 8 KiB pages. The first three pages follow their selectors. The top page at 0xE000 is pinned to the last ROM bank. A read into the unmapped and write-only area 0x7400–0x7FFF is flagged as open bus, so that the system keeps the previous bus value there.

The ROM bank count is a parameter, up to 64 banks of 8 KiB. Bank numbers wrap modulo that count.

Top module: `cart_cpu_banker`

## Requirements
- R1: While reset is asserted, and right after it is released, every register reads as zero on the exported buses. mirror_vert is 0 (horizontal) and chr_layout is 0. Pages at 0x8000, 0xA000 and 0xC000 map to bank 0.
- R2: A write to 0x7EF0+i, for i from 0 to 5, loads the full byte into character register i. It appears on chr_banks[8*i+7:8*i].
- R3: A write to 0x7EF6 sets mirror_vert from data bit 0 (1 = vertical) and chr_layout from data bit 1. Data bits 7:2 have no visible effect.
- R4: A write to 0x7EF7+k, for k from 0 to 2, loads the full byte into unlock key k. It appears on unlock_keys[8*k+7:8*k].
- R5: A write to 0x7EFA, 0x7EFB or 0x7EFC sets the bank for 0x8000, 0xA000 or 0xC000 respectively. The bank is (data >> 2) mod PRG_BANKS, so data bits 1:0 are dropped. A read in that page gives rom_addr = bank*8192 + cpu_addr[12:0].
- R6: A read in 0xE000–0xFFFF gives rom_addr = (PRG_BANKS-1)*8192 + cpu_addr[12:0], whatever the register writes have been.
- R7: open_bus is 1 exactly when cpu_rd is 1 and cpu_addr lies in 0x7400–0x7FFF, which includes the register window. In that case rom_rd is 0.
- R8: rom_rd is 1 exactly when cpu_rd is 1 and cpu_addr[15] is 1.
- R9: The following change no exported state: writes to 0x7EFD–0x7EFF, writes outside 0x7EF0–0x7EFF, and cycles with cpu_wr low.
- R10: A register write takes effect at the rising clock edge that ends the write cycle. Before that edge the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read cycle |
| cpu_wr | input | 1 | CPU write cycle |
| rom_addr | output | ROM_ADDR_W | Program ROM byte address (clog2(PRG_BANKS)+13 bits) |
| rom_rd | output | 1 | Program ROM read enable |
| open_bus | output | 1 | Read with no driver; bus keeps its old value |
| chr_banks | output | 48 | Character registers 0–5, register i in bits 8i+7:8i |
| chr_layout | output | 1 | Character layout mode bit |
| mirror_vert | output | 1 | Mirroring: 1 vertical, 0 horizontal |
| unlock_keys | output | 24 | Unlock keys 0–2, key k in bits 8k+7:8k |

## Verification
The bank wrap is the hardest behaviour to reach from the ports. It only shows when the bank count is not a power of two and the selector value is at least that count. The bench therefore builds the block with 11 banks. For each of the three selectors it sweeps all 256 written bytes, so that every raw bank from 0 to 63 and every pair of dropped low bits is seen. The bench then reads back at offsets that vary with the data. The write-to-effect edge is checked by sampling the outputs in the middle of a write cycle, before the capturing edge, and again after it.

// File: rtl/cpu_bank_pkg.sv
`timescale 1ns/1ps
package cpu_bank_pkg;

  // Register window: address bits 15:4 match this tag
  localparam logic [11:0] WIN_TAG = 12'h7EF;

  // Slot layout inside the window (low nibble of the address)
  localparam int NUM_SLOTS = 13;
  localparam int CHR_FIRST = 0;
  localparam int CHR_COUNT = 6;
  localparam int CTRL_SLOT = 6;
  localparam int KEY_FIRST = 7;
  localparam int KEY_COUNT = 3;
  localparam int SEL_FIRST = 10;
  localparam int SEL_COUNT = 3;

  localparam int DATA_W    = 8;
  localparam int SEL_W     = 6;   // bank number = data[7:2]
  localparam int PAGE_BITS = 13;  // 8 KiB pages

  typedef struct packed {
    logic chr_layout;
    logic mirror_vert;
  } ctrl_t;

  // Bank arithmetic: raw selector folded into the configured bank count
  function automatic int unsigned wrap_bank(input logic [SEL_W-1:0] raw,
                                            input int unsigned count);
    return int'(raw) % count;
  endfunction

  // Selector value kept from a written byte
  function automatic logic [SEL_W-1:0] sel_from_byte(input logic [DATA_W-1:0] d);
    return d[DATA_W-1:2];
  endfunction

endpackage

// File: rtl/cpu_reg_decode.sv
`timescale 1ns/1ps
module cpu_reg_decode
  import cpu_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic                 cpu_wr,
  output logic [NUM_SLOTS-1:0] slot_we
);

  logic win_hit;
  assign win_hit = (cpu_addr[15:4] == WIN_TAG);

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign slot_we[s] = cpu_wr && win_hit && (cpu_addr[3:0] == 4'(s));
    end
  endgenerate

  // A strobe only ever comes from a CPU write into page 0x7E
  assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_we) |-> (cpu_wr && cpu_addr[15:8] == 8'h7E));

endmodule

// File: rtl/cpu_reg_bank.sv
`timescale 1ns/1ps
module cpu_reg_bank
  import cpu_bank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SLOTS-1:0]           slot_we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [CHR_COUNT*DATA_W-1:0]    chr_flat,
  output ctrl_t                          ctrl_q,
  output logic [KEY_COUNT*DATA_W-1:0]    key_flat,
  output logic [SEL_COUNT*SEL_W-1:0]     sel_flat
);

  genvar i;
  generate
    for (i = 0; i < CHR_COUNT; i++) begin : g_chr
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= '0;
        else if (slot_we[CHR_FIRST+i]) q <= wdata;
      end
      assign chr_flat[i*DATA_W +: DATA_W] = q;

      assert_chr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we[CHR_FIRST+i] |=> (chr_flat[i*DATA_W +: DATA_W] == $past(wdata)));
    end

    for (i = 0; i < KEY_COUNT; i++) begin : g_key
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= '0;
        else if (slot_we[KEY_FIRST+i]) q <= wdata;
      end
      assign key_flat[i*DATA_W +: DATA_W] = q;
    end

    for (i = 0; i < SEL_COUNT; i++) begin : g_sel
      logic [SEL_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= '0;
        else if (slot_we[SEL_FIRST+i]) q <= sel_from_byte(wdata);
      end
      assign sel_flat[i*SEL_W +: SEL_W] = q;

      assert_sel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we[SEL_FIRST+i] |=> (sel_flat[i*SEL_W +: SEL_W] == $past(wdata[DATA_W-1:2])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (slot_we[CTRL_SLOT]) begin
      ctrl_q.mirror_vert <= wdata[0];
      ctrl_q.chr_layout  <= wdata[1];
    end
  end

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_we[CTRL_SLOT] |=> (ctrl_q == {$past(wdata[1]), $past(wdata[0])}));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_we) |=> ($stable(chr_flat) && $stable(ctrl_q) &&
                     $stable(key_flat) && $stable(sel_flat)));

endmodule

// File: rtl/cpu_prg_xlate.sv
`timescale 1ns/1ps
module cpu_prg_xlate
  import cpu_bank_pkg::*;
#(
  parameter  int PRG_BANKS  = 64,
  localparam int BANK_W     = $clog2(PRG_BANKS),
  localparam int ROM_ADDR_W = BANK_W + PAGE_BITS
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [15:0]                cpu_addr,
  input  logic                       cpu_rd,
  input  logic [SEL_COUNT*SEL_W-1:0] sel_flat,
  output logic [ROM_ADDR_W-1:0]      rom_addr,
  output logic                       rom_rd,
  output logic                       open_bus
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(PRG_BANKS - 1);

  // Per-page folded banks
  logic [BANK_W-1:0] page_bank [4];

  genvar p;
  generate
    for (p = 0; p < SEL_COUNT; p++) begin : g_page
      assign page_bank[p] = BANK_W'(wrap_bank(sel_flat[p*SEL_W +: SEL_W], PRG_BANKS));
    end
  endgenerate
  assign page_bank[3] = LAST_BANK;

  logic [BANK_W-1:0] cur_bank;
  assign cur_bank = page_bank[cpu_addr[14:13]];
  assign rom_addr = {cur_bank, cpu_addr[PAGE_BITS-1:0]};

  logic in_rom, in_hole;
  assign in_rom  = cpu_addr[15];
  assign in_hole = (cpu_addr[15:12] == 4'h7) && (cpu_addr[11:10] != 2'b00);

  assign rom_rd   = cpu_rd && in_rom;
  assign open_bus = cpu_rd && in_hole;

  assert_fixed_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && cpu_addr[15:13] == 3'b111) |->
      (rom_addr[ROM_ADDR_W-1:PAGE_BITS] == BANK_W'(PRG_BANKS - 1)));

  assert_open_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus |-> (cpu_rd && !rom_rd && cpu_addr[15:10] >= 6'h1D && cpu_addr[15:10] <= 6'h1F));

  assert_rom_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> (cpu_rd && cpu_addr >= 16'h8000));

endmodule

// File: rtl/cart_cpu_banker.sv
`timescale 1ns/1ps
module cart_cpu_banker
  import cpu_bank_pkg::*;
#(
  parameter  int PRG_BANKS  = 64,
  localparam int ROM_ADDR_W = $clog2(PRG_BANKS) + 13
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_wdata,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  output logic                  rom_rd,
  output logic                  open_bus,
  output logic [47:0]           chr_banks,
  output logic                  chr_layout,
  output logic                  mirror_vert,
  output logic [23:0]           unlock_keys
);

  logic [NUM_SLOTS-1:0]       slot_we;
  ctrl_t                      ctrl_q;
  logic [SEL_COUNT*SEL_W-1:0] sel_flat;

  cpu_reg_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .slot_we  (slot_we)
  );

  cpu_reg_bank u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_we  (slot_we),
    .wdata    (cpu_wdata),
    .chr_flat (chr_banks),
    .ctrl_q   (ctrl_q),
    .key_flat (unlock_keys),
    .sel_flat (sel_flat)
  );

  cpu_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_rd   (cpu_rd),
    .sel_flat (sel_flat),
    .rom_addr (rom_addr),
    .rom_rd   (rom_rd),
    .open_bus (open_bus)
  );

  assign chr_layout  = ctrl_q.chr_layout;
  assign mirror_vert = ctrl_q.mirror_vert;

endmodule

// File: tb/cart_cpu_banker_bench.sv
`timescale 1ns/1ps
module cart_cpu_banker_bench;

  localparam int NB = 11;
  localparam int AW = $clog2(NB) + 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic          cpu_rd = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [AW-1:0] rom_addr;
  logic          rom_rd, open_bus, chr_layout, mirror_vert;
  logic [47:0]   chr_banks;
  logic [23:0]   unlock_keys;

  cart_cpu_banker #(.PRG_BANKS(NB)) u_cart_cpu_banker (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_rd(rom_rd),
    .open_bus(open_bus), .chr_banks(chr_banks), .chr_layout(chr_layout),
    .mirror_vert(mirror_vert), .unlock_keys(unlock_keys)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // Reference model of the register state
  logic [7:0] chr_m [6];
  logic [7:0] key_m [3];
  logic [5:0] sel_m [3];
  logic       mir_m, lay_m;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 6; i++) chr_m[i] = '0;
    for (int i = 0; i < 3; i++) begin key_m[i] = '0; sel_m[i] = '0; end
    mir_m = 1'b0; lay_m = 1'b0;
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    if (a >= 16'h7EF0 && a <= 16'h7EF5) chr_m[a - 16'h7EF0] = d;
    else if (a == 16'h7EF6) begin mir_m = d[0]; lay_m = d[1]; end
    else if (a >= 16'h7EF7 && a <= 16'h7EF9) key_m[a - 16'h7EF7] = d;
    else if (a >= 16'h7EFA && a <= 16'h7EFC) sel_m[a - 16'h7EFA] = d / 4;
  endfunction

  function automatic logic [63:0] exp_rom(input int page, input int ofs);
    int bank;
    bank = (page == 3) ? NB - 1 : sel_m[page] % NB;
    return 64'(bank * 8192 + ofs);
  endfunction

  function automatic logic [47:0] chr_exp();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = chr_m[i];
    return v;
  endfunction

  function automatic logic [23:0] key_exp();
    logic [23:0] v;
    for (int i = 0; i < 3; i++) v[i*8 +: 8] = key_m[i];
    return v;
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit strobe);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = strobe; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
    if (strobe) model_write(a, d);
  endtask

  task automatic read_rom(input string req, input int page, input int ofs);
    @(negedge clk);
    cpu_addr = 16'(16'h8000 + page * 16'h2000 + ofs); cpu_rd = 1'b1;
    #1;
    check(req, "rom_addr", 64'(rom_addr), exp_rom(page, ofs));
    check(req, "rom_rd", 64'(rom_rd), 64'(1));
    cpu_rd = 1'b0;
  endtask

  task automatic check_regs(input string req);
    #1;
    check(req, "chr_banks", 64'(chr_banks), 64'(chr_exp()));
    check(req, "unlock_keys", 64'(unlock_keys), 64'(key_exp()));
    check(req, "mirror_vert", 64'(mirror_vert), 64'(mir_m));
    check(req, "chr_layout", 64'(chr_layout), 64'(lay_m));
  endtask

  task automatic check_all(input string req);
    check_regs(req);
    for (int p = 0; p < 4; p++) read_rom(req, p, 16'h0123 + p);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state while in reset
    check_regs("R1");
    rst_n = 1'b1;
    // R1 after release, R6 top page fixed
    check_all("R1");
    read_rom("R6", 3, 16'h1FFF);

    // R2: character registers
    for (int i = 0; i < 6; i++) begin
      bus_write(16'(16'h7EF0 + i), 8'(8'hA5 ^ (i * 37)), 1'b1);
      check_regs("R2");
    end

    // R3: control register, all 256 values
    for (int v = 0; v < 256; v++) begin
      bus_write(16'h7EF6, 8'(v), 1'b1);
      check_regs("R3");
    end

    // R4: unlock keys
    bus_write(16'h7EF7, 8'hCA, 1'b1);
    bus_write(16'h7EF8, 8'h69, 1'b1);
    bus_write(16'h7EF9, 8'h84, 1'b1);
    check_regs("R4");

    // R5: exhaustive selector sweep with bank wrap
    for (int p = 0; p < 3; p++) begin
      for (int v = 0; v < 256; v++) begin
        bus_write(16'(16'h7EFA + p), 8'(v), 1'b1);
        read_rom("R5", p, (v * 29) & 16'h1FFF);
      end
    end
    bus_write(16'h7EFA, 8'd62 << 2, 1'b1);
    bus_write(16'h7EFB, 8'd9 << 2 | 8'd3, 1'b1);
    bus_write(16'h7EFC, 8'd44 << 2, 1'b1);
    check_all("R5");
    // R6: top page still fixed after selector writes
    read_rom("R6", 3, 0);
    read_rom("R6", 3, 16'h1ABC);

    // R9: ignored writes
    bus_write(16'h7EFD, 8'hFF, 1'b1);
    bus_write(16'h7EFE, 8'hFF, 1'b1);
    bus_write(16'h7EFF, 8'hFF, 1'b1);
    bus_write(16'h7EEF, 8'hFF, 1'b1);
    bus_write(16'h7F00, 8'hFF, 1'b1);
    bus_write(16'h6000, 8'hFF, 1'b1);
    bus_write(16'hFEFA, 8'hFF, 1'b1);
    bus_write(16'h7EFA, 8'hFF, 1'b0);
    bus_write(16'h7EF0, 8'h00, 1'b0);
    bus_write(16'h7EF6, 8'h00, 1'b0);
    check_all("R9");

    // R7 / R8: read decode sweep
    for (int a = 0; a < 256; a++) begin
      for (int lo = 0; lo < 2; lo++) begin
        logic [15:0] addr;
        addr = 16'((a << 8) | (lo ? 16'hFF : 16'h00));
        @(negedge clk);
        cpu_addr = addr; cpu_rd = 1'b1;
        #1;
        check("R7", "open_bus", 64'(open_bus), 64'(addr >= 16'h7400 && addr <= 16'h7FFF));
        check("R8", "rom_rd", 64'(rom_rd), 64'(addr >= 16'h8000));
        cpu_rd = 1'b0;
        #1;
        check("R7", "open_bus idle", 64'(open_bus), 64'(0));
        check("R8", "rom_rd idle", 64'(rom_rd), 64'(0));
      end
    end
    @(negedge clk);
    cpu_addr = 16'h73FF; cpu_rd = 1'b1; #1;
    check("R7", "open_bus 73FF", 64'(open_bus), 64'(0));
    cpu_addr = 16'h7400; #1;
    check("R7", "open_bus 7400", 64'(open_bus), 64'(1));
    cpu_rd = 1'b0;

    // R10: write takes effect at the capturing edge
    @(negedge clk);
    cpu_addr = 16'h7EF3; cpu_wdata = 8'h3C; cpu_wr = 1'b1;
    #1;
    check("R10", "chr3 before edge", 64'(chr_banks[31:24]), 64'(chr_m[3]));
    @(posedge clk);
    #1;
    check("R10", "chr3 after edge", 64'(chr_banks[31:24]), 64'(8'h3C));
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
    chr_m[3] = 8'h3C;

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    check_regs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule